// File: doc/BRIEF.md
# Region Protection and Translation Checker

This block checks and translates memory accesses for a core that has no paging unit. The 32-bit address space is cut into eight equal regions of 512 MiB. The top three address bits pick one region. In region mode, each region holds a physical base, which is the top three bits of the physical address, and a 4-bit attribute. The attribute encodes, through a fixed table, the read, write and execute rights and the cache policy.

A request gives an address and an access kind. One cycle later the block returns the physical address, the rights, the cache policy, and a fault flag with a cause when the access kind lacks the right it needs.

A second mode takes the attribute nibble from a 32-bit cache-attribute word at the block's input. In that mode addresses pass through untranslated. A write port loads one region's base and attribute.

Top module: `region_guard`

## Requirements
- R1: The region index is `req_addr[31:29]`. In region mode (`cattr_mode`=0), `rsp_paddr` = {region base (3 bits), `req_addr[28:0]`}.
- R2: After reset, region i has base i (identity translation) and attribute 2.
- R3: In either mode the attribute decodes as follows (rights as rd/wr/ex; cache code 0 none, 1 write-through, 2 write-back, 3 bypass, 4 isolate):
  - 0: rd, wr, cache 1
  - 1: rd, wr, ex, cache 1
  - 2: rd, wr, ex, cache 3
  - 3: ex only, cache 2
  - 4: rd, wr, ex, cache 2
  - 14: rd, wr, cache 4
- R4: Attribute 5 gives rd, wr, ex with cache 2 in region mode only. In cache-attribute mode, attribute 5 and every attribute not listed in R3 give no rights and cache 0. The same no-rights result holds for unlisted values in region mode.
- R5: In cache-attribute mode (`cattr_mode`=1), the attribute is `cattr_word[4*idx+3:4*idx]` and `rsp_paddr` equals `req_addr`.
- R6: `req_kind` selects the right needed: 0 load needs rd, 1 store needs wr, 2 fetch needs ex. When that right is missing, `rsp_fault`=1 and `rsp_cause` is 1 for load, 2 for store and 3 for fetch. Otherwise `rsp_fault`=0 and `rsp_cause`=0.
- R7: A request accepted on a clock edge shows its result, with `rsp_valid`=1, right after the next edge. A cycle without a request gives `rsp_valid`=0 and all other response outputs 0.
- R8: A write (`wr_en`) to region `wr_idx` takes effect for requests from the next cycle on. A request in the same cycle as the write sees the old entry.
- R9: While in reset, every output is 0.
- R10: `req_kind`=3 is checked as a load, with cause 1 on fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 as load |
| cattr_mode | input | 1 | 0 region table, 1 cache-attribute word |
| cattr_word | input | 32 | Eight attribute nibbles, one per region |
| wr_en | input | 1 | Load a region entry |
| wr_idx | input | 3 | Region to load |
| wr_base | input | 3 | New physical base bits [31:29] |
| wr_attr | input | 4 | New attribute |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |
| rsp_ex | output | 1 | Execute allowed |
| rsp_cache | output | 3 | Cache policy code |
| rsp_fault | output | 1 | Access kind not allowed |
| rsp_cause | output | 2 | Fault cause code |

## Verification
A corrupted region entry shows at the ports on the first request that touches that region. It appears as a wrong top three bits of `rsp_paddr` or as wrong rights, one cycle after the request. A wrong index or nibble select shows as rights taken from a neighbouring region, so the bench sweeps all eight regions with distinct attributes. A write that lands a cycle early or late shows only on a request to that region issued alongside the write or right after it. The bench therefore places requests at exactly those cycles.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CP_NONE    = 3'd0,
        CP_WTHRU   = 3'd1,
        CP_WBACK   = 3'd2,
        CP_BYPASS  = 3'd3,
        CP_ISOLATE = 3'd4
    } cache_pol_e;

    typedef enum logic [1:0] {
        CZ_NONE  = 2'd0,
        CZ_LOAD  = 2'd1,
        CZ_STORE = 2'd2,
        CZ_FETCH = 2'd3
    } cause_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

endpackage

// File: rtl/rgn_table.sv
module rgn_table #(
    parameter int IDX_W      = 3,
    parameter int ATTR_W     = 4,
    parameter int RESET_ATTR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  wr_base,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  rd_base,
    output logic [ATTR_W-1:0] rd_attr
);
    localparam int NREG = 1 << IDX_W;

    logic [IDX_W-1:0]  base_q [NREG];
    logic [ATTR_W-1:0] attr_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        logic [IDX_W-1:0]  base_d;
        logic [ATTR_W-1:0] attr_d;
        logic              hit;

        always_comb begin
            hit    = wr_en && (wr_idx == IDX_W'(g));
            base_d = hit ? wr_base : base_q[g];
            attr_d = hit ? wr_attr : attr_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= IDX_W'(g);
                attr_q[g] <= ATTR_W'(RESET_ATTR);
            end else begin
                base_q[g] <= base_d;
                attr_q[g] <= attr_d;
            end
        end
    end

    always_comb begin
        rd_base = base_q[rd_idx];
        rd_attr = attr_q[rd_idx];
    end
endmodule

// File: rtl/rgn_attr_decode.sv
module rgn_attr_decode
    import rgn_guard_pkg::*;
#(
    parameter int ATTR_W = 4
) (
    input  logic [ATTR_W-1:0] attr,
    input  logic              cattr_mode,
    output rights_t           rights,
    output cache_pol_e        policy
);
    always_comb begin
        rights = '0;
        policy = CP_NONE;
        case (attr)
            ATTR_W'(0):  begin rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b0}; policy = CP_WTHRU;   end
            ATTR_W'(1):  begin rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1}; policy = CP_WTHRU;   end
            ATTR_W'(2):  begin rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1}; policy = CP_BYPASS;  end
            ATTR_W'(3):  begin rights = '{rd: 1'b0, wr: 1'b0, ex: 1'b1}; policy = CP_WBACK;   end
            ATTR_W'(4):  begin rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1}; policy = CP_WBACK;   end
            ATTR_W'(5):  begin
                if (!cattr_mode) begin
                    rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
                    policy = CP_WBACK;
                end
            end
            ATTR_W'(14): begin rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b0}; policy = CP_ISOLATE; end
            default: begin
                rights = '0;
                policy = CP_NONE;
            end
        endcase
    end
endmodule

// File: rtl/region_guard.sv
module region_guard
    import rgn_guard_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 3,
    parameter int ATTR_W     = 4,
    parameter int RESET_ATTR = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [1:0]                     req_kind,
    input  logic                           cattr_mode,
    input  logic [(1<<IDX_W)*ATTR_W-1:0]   cattr_word,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [IDX_W-1:0]               wr_base,
    input  logic [ATTR_W-1:0]              wr_attr,
    output logic                           rsp_valid,
    output logic [ADDR_W-1:0]              rsp_paddr,
    output logic                           rsp_rd,
    output logic                           rsp_wr,
    output logic                           rsp_ex,
    output logic [2:0]                     rsp_cache,
    output logic                           rsp_fault,
    output logic [1:0]                     rsp_cause
);
    localparam int OFF_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] paddr;
        rights_t           rights;
        cache_pol_e        policy;
        logic              fault;
        cause_e            cause;
    } rsp_t;

    logic [IDX_W-1:0]  region;
    logic [IDX_W-1:0]  tbl_base;
    logic [ATTR_W-1:0] tbl_attr;
    logic [ATTR_W-1:0] sel_attr;
    rights_t           dec_rights;
    cache_pol_e        dec_policy;
    rsp_t              rsp_d, rsp_q;

    assign region = req_addr[ADDR_W-1 -: IDX_W];

    rgn_table #(
        .IDX_W      (IDX_W),
        .ATTR_W     (ATTR_W),
        .RESET_ATTR (RESET_ATTR)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_base (wr_base),
        .wr_attr (wr_attr),
        .rd_idx  (region),
        .rd_base (tbl_base),
        .rd_attr (tbl_attr)
    );

    always_comb begin
        sel_attr = cattr_mode ? cattr_word[region*ATTR_W +: ATTR_W] : tbl_attr;
    end

    rgn_attr_decode #(
        .ATTR_W (ATTR_W)
    ) u_decode (
        .attr       (sel_attr),
        .cattr_mode (cattr_mode),
        .rights     (dec_rights),
        .policy     (dec_policy)
    );

    always_comb begin
        logic   allowed;
        cause_e deny_cause;

        case (acc_kind_e'(req_kind))
            ACC_STORE: begin allowed = dec_rights.wr; deny_cause = CZ_STORE; end
            ACC_FETCH: begin allowed = dec_rights.ex; deny_cause = CZ_FETCH; end
            default:   begin allowed = dec_rights.rd; deny_cause = CZ_LOAD;  end
        endcase

        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid  = 1'b1;
            rsp_d.paddr  = cattr_mode ? req_addr : {tbl_base, req_addr[OFF_W-1:0]};
            rsp_d.rights = dec_rights;
            rsp_d.policy = dec_policy;
            rsp_d.fault  = !allowed;
            rsp_d.cause  = allowed ? CZ_NONE : deny_cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_rd    = rsp_q.rights.rd;
    assign rsp_wr    = rsp_q.rights.wr;
    assign rsp_ex    = rsp_q.rights.ex;
    assign rsp_cache = rsp_q.policy;
    assign rsp_fault = rsp_q.fault;
    assign rsp_cause = rsp_q.cause;
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_kind,
    input logic              cattr_mode,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_rd,
    input logic              rsp_wr,
    input logic              rsp_ex,
    input logic              rsp_fault,
    input logic [1:0]        rsp_cause
);
    localparam int OFF_W = ADDR_W - IDX_W;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R7
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault)); // R7
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))); // R1
    AST_CATTR_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cattr_mode) |=> (rsp_paddr == $past(req_addr))); // R5
    AST_STORE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1) |=> (rsp_fault == !rsp_wr)); // R6
    AST_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> (rsp_fault == !rsp_ex)); // R6
    AST_RSVD_AS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> (rsp_fault == !rsp_rd)); // R10
    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_cause != 2'd0)); // R6
endmodule

bind region_guard region_guard_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/region_guard_test.sv
module region_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        cattr_mode = 1'b0;
    logic [31:0] cattr_word = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [2:0]  wr_base = '0;
    logic [3:0]  wr_attr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_rd, rsp_wr, rsp_ex;
    logic [2:0]  rsp_cache;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;

    int checks = 0;
    int fails  = 0;
    logic [2:0] m_base [8];
    logic [3:0] m_attr [8];

    always #4 clk = ~clk;

    region_guard uut (.*);

    // Expected response {valid, paddr, rd, wr, ex, cache, fault, cause}
    function automatic logic [41:0] expect_rsp(input logic v, input logic [31:0] a,
                                               input logic [1:0] k, input logic m,
                                               input logic [31:0] cw);
        logic [2:0] idx;
        logic [3:0] at;
        logic [31:0] pa;
        logic r, w, x, need;
        logic [2:0] c;
        logic [1:0] cz;
        if (!v) return '0;
        idx = a[31:29];
        at  = m ? cw[idx*4 +: 4] : m_attr[idx];
        pa  = m ? a : {m_base[idx], a[28:0]};
        {r, w, x, c} = 6'b000_000;
        if      (at == 4'd0)  {r, w, x, c} = {3'b110, 3'd1};
        else if (at == 4'd1)  {r, w, x, c} = {3'b111, 3'd1};
        else if (at == 4'd2)  {r, w, x, c} = {3'b111, 3'd3};
        else if (at == 4'd3)  {r, w, x, c} = {3'b001, 3'd2};
        else if (at == 4'd4)  {r, w, x, c} = {3'b111, 3'd2};
        else if (at == 4'd5 && !m) {r, w, x, c} = {3'b111, 3'd2};
        else if (at == 4'd14) {r, w, x, c} = {3'b110, 3'd4};
        if (k == 2'd1)      begin need = w; cz = 2'd2; end
        else if (k == 2'd2) begin need = x; cz = 2'd3; end
        else                begin need = r; cz = 2'd1; end
        return {1'b1, pa, r, w, x, c, !need, need ? 2'd0 : cz};
    endfunction

    function automatic logic [41:0] actual_rsp();
        return {rsp_valid, rsp_paddr, rsp_rd, rsp_wr, rsp_ex, rsp_cache, rsp_fault, rsp_cause};
    endfunction

    task automatic check(input string tag, input logic [41:0] exp);
        checks++;
        if (actual_rsp() !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, actual_rsp(), exp);
        end
    endtask

    // Called at a falling edge; the result is compared one clock later.
    task automatic step(input string tag, input logic v, input logic [31:0] a,
                        input logic [1:0] k, input logic m, input logic [31:0] cw,
                        input logic we, input logic [2:0] wi, input logic [2:0] wb,
                        input logic [3:0] wa);
        logic [41:0] exp;
        exp = expect_rsp(v, a, k, m, cw);
        req_valid = v; req_addr = a; req_kind = k; cattr_mode = m; cattr_word = cw;
        wr_en = we; wr_idx = wi; wr_base = wb; wr_attr = wa;
        @(posedge clk);
        if (we) begin m_base[wi] = wb; m_attr[wi] = wa; end
        @(negedge clk);
        check(tag, exp);
    endtask

    task automatic load_entry(input logic [2:0] wi, input logic [2:0] wb, input logic [3:0] wa);
        step("R8", 1'b0, '0, 2'd0, 1'b0, '0, 1'b1, wi, wb, wa);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] dummy;
        for (int i = 0; i < 8; i++) begin m_base[i] = 3'(i); m_attr[i] = 4'd2; end
        dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R9 reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle", '0);

        // R2: identity, attribute 2 after reset, every kind
        for (int i = 0; i < 8; i++)
            for (int k = 0; k < 3; k++)
                step("R2", 1'b1, {3'(i), 29'h0ABC_DEF0 ^ 29'(i)}, 2'(k), 1'b0, '0, 1'b0, '0, '0, '0);

        // R3/R4: every attribute value in region mode, all kinds
        for (int at = 0; at < 16; at++) begin
            load_entry(3'd5, 3'd1, 4'(at));
            for (int k = 0; k < 4; k++)
                step(k == 3 ? "R10" : "R3 R4 R6", 1'b1, 32'hA123_4567, 2'(k), 1'b0, '0,
                     1'b0, '0, '0, '0);
        end

        // R5/R4: cache-attribute mode, distinct nibble per region
        for (int rot = 0; rot < 16; rot++) begin
            logic [31:0] cw;
            for (int n = 0; n < 8; n++) cw[n*4 +: 4] = 4'((n + rot) % 16);
            for (int i = 0; i < 8; i++)
                for (int k = 0; k < 3; k++)
                    step("R5 R4", 1'b1, {3'(i), 29'h1555_0001}, 2'(k), 1'b1, cw, 1'b0, '0, '0, '0);
        end

        // R8: request alongside a write sees old entry, next cycle sees new one
        step("R8 same cycle", 1'b1, 32'h4000_0010, 2'd1, 1'b0, '0, 1'b1, 3'd2, 3'd6, 4'd3);
        step("R8 next cycle", 1'b1, 32'h4000_0010, 2'd1, 1'b0, '0, 1'b0, '0, '0, '0);
        step("R1 translated", 1'b1, 32'h5FFF_FFFF, 2'd2, 1'b0, '0, 1'b0, '0, '0, '0);
        step("R7 gap", 1'b0, 32'hFFFF_FFFF, 2'd1, 1'b0, '1, 1'b0, '0, '0, '0);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            step("R1 R3 R5 R6 R7 R8 random", ($urandom % 8) != 0, $urandom, 2'($urandom),
                 1'($urandom), $urandom, ($urandom % 5) == 0, 3'($urandom), 3'($urandom),
                 4'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule